// File: doc/BRIEF.md
# Issue Queue Wakeup and Squash

This block is the entry array of an out-of-order issue queue. Each entry holds an instruction's sequence number, its execution class and two renamed source tags, each with a ready bit. A scoreboard with one bit per physical register records which results already exist. The array accepts one dispatch, one result broadcast, one non-speculative release, one squash and one issue grant per cycle. It presents per-class ready vectors to an external selector, together with the number of free entries and a full flag.

A dispatched source that the renamer marked not-ready is still captured as ready when the scoreboard already holds its result, or when that result is broadcast in the dispatch cycle. Tags at or above the physical register count are not tracked and never hold back issue. A result broadcast wakes matching waiting sources in the same cycle. A squash removes unissued entries younger than a given sequence number. Non-speculative instructions wait for a release that carries their sequence number.

Top module: `iq_wakeup_array`

## Requirements
- R1: After reset every entry is empty, `free_cnt_o` equals the entry count, `full_o` is low, all ready vectors are zero, and every scoreboard bit reads not-ready.
- R2: A dispatch writes the lowest-numbered empty entry. The free count is one lower from the next cycle on.
- R3: A dispatch with a tracked destination tag clears that register's scoreboard bit. A later consumer that relies on the scoreboard then waits.
- R4: At dispatch, a source marked not-ready whose scoreboard bit is set is stored as ready.
- R5: A source tag equal to or above the physical register count never blocks readiness. A destination tag in that range changes no scoreboard bit.
- R6: A result broadcast sets the scoreboard bit of its tag. In the same cycle it makes ready every waiting source of a valid entry with that tag, and the source stays ready afterwards.
- R7: A source whose tag is broadcast in the cycle it is dispatched is stored as ready.
- R8: A ready entry appears in exactly one ready vector, chosen from dispatch flags (bit0 control, bit1 memory, bit2 integer, bit3 floating point) by the priority control, memory, integer, floating point. An entry with no flag set goes to the miscellaneous vector. Bit i of each vector is entry i.
- R9: A squash with sequence number S empties every valid entry whose sequence number is greater than S (unsigned). It keeps all other entries, and each removed entry adds one to the free count.
- R10: `full_o` is high exactly when the free count is zero. No dispatch may be presented while it is high.
- R11: A non-speculative dispatch ignores its source tags and is not ready until a release carries its exact sequence number. A release with any other sequence number has no effect on it.
- R12: An issue grant for entry i empties that entry. From the next cycle it no longer shows as ready and the free count is one higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_seq_i | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_flags_i | input | 4 | Class flags: bit0 control, bit1 memory, bit2 integer, bit3 floating point |
| disp_nonspec_i | input | 1 | Instruction must wait for a release |
| disp_src0_tag_i | input | TAG_W | First source physical tag |
| disp_src0_rdy_i | input | 1 | First source known ready at rename |
| disp_src1_tag_i | input | TAG_W | Second source physical tag |
| disp_src1_rdy_i | input | 1 | Second source known ready at rename |
| disp_dst_valid_i | input | 1 | Instruction writes a destination |
| disp_dst_tag_i | input | TAG_W | Destination physical tag |
| cmpl_valid_i | input | 1 | Result broadcast |
| cmpl_tag_i | input | TAG_W | Broadcast destination tag |
| sched_valid_i | input | 1 | Non-speculative release |
| sched_seq_i | input | SEQ_W | Sequence number being released |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Youngest surviving sequence number |
| grant_valid_i | input | 1 | Issue grant from the selector |
| grant_idx_i | input | IDX_W | Granted entry index |
| rdy_ctrl_o | output | N_ENTRIES | Ready control entries |
| rdy_mem_o | output | N_ENTRIES | Ready memory entries |
| rdy_int_o | output | N_ENTRIES | Ready integer entries |
| rdy_fp_o | output | N_ENTRIES | Ready floating point entries |
| rdy_misc_o | output | N_ENTRIES | Ready miscellaneous entries |
| free_cnt_o | output | CNT_W | Number of empty entries |
| full_o | output | 1 | No empty entry |

## Verification
The bench targets a source whose result was broadcast before dispatch, or in the very dispatch cycle. A design that trusted only the rename ready bit would leave that entry waiting forever. It checks that a broadcast shows on the ready vectors in the same cycle; a design with a registered wakeup would be one cycle late there. Squash boundaries are tested with entries equal to, older than and younger than S. An off-by-one compare would remove the boundary entry or keep a younger one, and the free count would drift. Releases carry both wrong and right sequence numbers, and a multi-flag instruction must land in one list only. A wrong priority would offer it to two selectors or to the wrong one.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int FL_CTRL = 0;
  localparam int FL_MEM  = 1;
  localparam int FL_INT  = 2;
  localparam int FL_FP   = 3;
  localparam int N_FLAGS = 4;

  typedef enum logic [2:0] {
    CLS_CTRL = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_INT  = 3'd2,
    CLS_FP   = 3'd3,
    CLS_MISC = 3'd4
  } iq_cls_e;

  function automatic iq_cls_e flags_to_cls(input logic [N_FLAGS-1:0] fl);
    if (fl[FL_CTRL])     return CLS_CTRL;
    else if (fl[FL_MEM]) return CLS_MEM;
    else if (fl[FL_INT]) return CLS_INT;
    else if (fl[FL_FP])  return CLS_FP;
    else                 return CLS_MISC;
  endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int N_PREGS = 32,
  parameter int TAG_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_v_i,
  input  logic [TAG_W-1:0]   set_tag_i,
  input  logic               clr_v_i,
  input  logic [TAG_W-1:0]   clr_tag_i,
  output logic [N_PREGS-1:0] sb_o
);
  for (genvar g = 0; g < N_PREGS; g++) begin : g_bit
    // newer producer wins over an older result on the same tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sb_o[g] <= 1'b0;
      else if (clr_v_i && clr_tag_i == TAG_W'(g))    sb_o[g] <= 1'b0;
      else if (set_v_i && set_tag_i == TAG_W'(g))    sb_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int N_ENTRIES = 8
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  output logic [N_ENTRIES-1:0] pick_o,
  output logic                 any_free_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
    any_free_o = found;
  end
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] a_seq_i,
  input  iq_cls_e          a_cls_i,
  input  logic             a_wait_i,
  input  logic [TAG_W-1:0] a_t0_i,
  input  logic             a_r0_i,
  input  logic [TAG_W-1:0] a_t1_i,
  input  logic             a_r1_i,
  input  logic             wk_v_i,
  input  logic [TAG_W-1:0] wk_tag_i,
  input  logic             sq_v_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  input  logic             sch_v_i,
  input  logic [SEQ_W-1:0] sch_seq_i,
  input  logic             gnt_i,
  output logic             valid_o,
  output logic             rdy_o,
  output iq_cls_e          cls_o
);
  logic [SEQ_W-1:0] seq_q;
  logic [TAG_W-1:0] t0_q, t1_q;
  logic             r0_q, r1_q, wait_q;
  logic             hit0, hit1;

  assign hit0 = wk_v_i && (wk_tag_i == t0_q);
  assign hit1 = wk_v_i && (wk_tag_i == t1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      seq_q   <= '0;
      cls_o   <= CLS_MISC;
      wait_q  <= 1'b0;
      t0_q    <= '0;
      t1_q    <= '0;
      r0_q    <= 1'b0;
      r1_q    <= 1'b0;
    end else if (alloc_i) begin
      valid_o <= 1'b1;
      seq_q   <= a_seq_i;
      cls_o   <= a_cls_i;
      wait_q  <= a_wait_i;
      t0_q    <= a_t0_i;
      t1_q    <= a_t1_i;
      r0_q    <= a_r0_i;
      r1_q    <= a_r1_i;
    end else if (valid_o) begin
      if (gnt_i || (sq_v_i && seq_q > sq_seq_i)) valid_o <= 1'b0;
      if (hit0) r0_q <= 1'b1;
      if (hit1) r1_q <= 1'b1;
      if (sch_v_i && sch_seq_i == seq_q) wait_q <= 1'b0;
    end
  end

  // broadcast bypass: wakeup visible in the broadcast cycle
  assign rdy_o = valid_o && !wait_q && (r0_q || hit0) && (r1_q || hit1);
endmodule

// File: rtl/iq_wakeup_array.sv
module iq_wakeup_array
  import iq_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int N_PREGS   = 32,
  parameter int TAG_W     = 6,
  parameter int SEQ_W     = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_valid_i,
  input  logic [SEQ_W-1:0]     disp_seq_i,
  input  logic [3:0]           disp_flags_i,
  input  logic                 disp_nonspec_i,
  input  logic [TAG_W-1:0]     disp_src0_tag_i,
  input  logic                 disp_src0_rdy_i,
  input  logic [TAG_W-1:0]     disp_src1_tag_i,
  input  logic                 disp_src1_rdy_i,
  input  logic                 disp_dst_valid_i,
  input  logic [TAG_W-1:0]     disp_dst_tag_i,
  input  logic                 cmpl_valid_i,
  input  logic [TAG_W-1:0]     cmpl_tag_i,
  input  logic                 sched_valid_i,
  input  logic [SEQ_W-1:0]     sched_seq_i,
  input  logic                 squash_valid_i,
  input  logic [SEQ_W-1:0]     squash_seq_i,
  input  logic                 grant_valid_i,
  input  logic [IDX_W-1:0]     grant_idx_i,
  output logic [N_ENTRIES-1:0] rdy_ctrl_o,
  output logic [N_ENTRIES-1:0] rdy_mem_o,
  output logic [N_ENTRIES-1:0] rdy_int_o,
  output logic [N_ENTRIES-1:0] rdy_fp_o,
  output logic [N_ENTRIES-1:0] rdy_misc_o,
  output logic [CNT_W-1:0]     free_cnt_o,
  output logic                 full_o
);
  localparam int SB_W = 2 ** TAG_W;
  localparam logic [TAG_W:0] PREG_LIM = (TAG_W + 1)'(N_PREGS);

  logic [N_PREGS-1:0]   sb_vec;
  logic [SB_W-1:0]      sb_ext;
  logic [N_ENTRIES-1:0] entry_valid, entry_rdy, pick;
  iq_cls_e              entry_cls [N_ENTRIES];
  logic                 any_free, disp_acc;
  logic                 s0_in, s1_in;
  iq_cls_e              disp_cls;

  assign sb_ext   = SB_W'(sb_vec);
  assign disp_acc = disp_valid_i && any_free;
  assign disp_cls = flags_to_cls(disp_flags_i);
  assign full_o   = !any_free;

  // insertion-time readiness: rename bit, untracked tag, scoreboard, same-cycle result
  always_comb begin
    s0_in = disp_nonspec_i || disp_src0_rdy_i || ({1'b0, disp_src0_tag_i} >= PREG_LIM)
         || sb_ext[disp_src0_tag_i] || (cmpl_valid_i && cmpl_tag_i == disp_src0_tag_i);
    s1_in = disp_nonspec_i || disp_src1_rdy_i || ({1'b0, disp_src1_tag_i} >= PREG_LIM)
         || sb_ext[disp_src1_tag_i] || (cmpl_valid_i && cmpl_tag_i == disp_src1_tag_i);
  end

  iq_scoreboard #(.N_PREGS(N_PREGS), .TAG_W(TAG_W)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_v_i   (cmpl_valid_i),
    .set_tag_i (cmpl_tag_i),
    .clr_v_i   (disp_acc && disp_dst_valid_i),
    .clr_tag_i (disp_dst_tag_i),
    .sb_o      (sb_vec)
  );

  iq_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
    .valid_i    (entry_valid),
    .pick_o     (pick),
    .any_free_o (any_free)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    iq_entry #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (disp_acc && pick[i]),
      .a_seq_i   (disp_seq_i),
      .a_cls_i   (disp_cls),
      .a_wait_i  (disp_nonspec_i),
      .a_t0_i    (disp_src0_tag_i),
      .a_r0_i    (s0_in),
      .a_t1_i    (disp_src1_tag_i),
      .a_r1_i    (s1_in),
      .wk_v_i    (cmpl_valid_i),
      .wk_tag_i  (cmpl_tag_i),
      .sq_v_i    (squash_valid_i),
      .sq_seq_i  (squash_seq_i),
      .sch_v_i   (sched_valid_i),
      .sch_seq_i (sched_seq_i),
      .gnt_i     (grant_valid_i && grant_idx_i == IDX_W'(i)),
      .valid_o   (entry_valid[i]),
      .rdy_o     (entry_rdy[i]),
      .cls_o     (entry_cls[i])
    );

    assign rdy_ctrl_o[i] = entry_rdy[i] && (entry_cls[i] == CLS_CTRL);
    assign rdy_mem_o[i]  = entry_rdy[i] && (entry_cls[i] == CLS_MEM);
    assign rdy_int_o[i]  = entry_rdy[i] && (entry_cls[i] == CLS_INT);
    assign rdy_fp_o[i]   = entry_rdy[i] && (entry_cls[i] == CLS_FP);
    assign rdy_misc_o[i] = entry_rdy[i] && (entry_cls[i] == CLS_MISC);
  end

  always_comb begin
    free_cnt_o = CNT_W'(N_ENTRIES);
    for (int i = 0; i < N_ENTRIES; i++)
      if (entry_valid[i]) free_cnt_o = free_cnt_o - 1'b1;
  end
endmodule

// File: rtl/iq_wakeup_chk.sv
module iq_wakeup_chk #(
  parameter int N_ENTRIES = 8,
  parameter int N_PREGS   = 32,
  parameter int TAG_W     = 6,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 disp_valid_i,
  input logic                 disp_dst_valid_i,
  input logic [TAG_W-1:0]     disp_dst_tag_i,
  input logic                 cmpl_valid_i,
  input logic [TAG_W-1:0]     cmpl_tag_i,
  input logic                 squash_valid_i,
  input logic                 grant_valid_i,
  input logic [IDX_W-1:0]     grant_idx_i,
  input logic [N_ENTRIES-1:0] rdy_ctrl_o,
  input logic [N_ENTRIES-1:0] rdy_mem_o,
  input logic [N_ENTRIES-1:0] rdy_int_o,
  input logic [N_ENTRIES-1:0] rdy_fp_o,
  input logic [N_ENTRIES-1:0] rdy_misc_o,
  input logic [CNT_W-1:0]     free_cnt_o,
  input logic                 full_o,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_PREGS-1:0]   sb_q
);
  localparam int SB_W = 2 ** TAG_W;
  localparam logic [TAG_W:0] PREG_LIM = (TAG_W + 1)'(N_PREGS);
  logic [SB_W-1:0] sb_ext;
  assign sb_ext = SB_W'(sb_q);

  // R10
  no_disp_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !disp_valid_i);

  // R10
  full_matches_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (free_cnt_o == '0));

  // R8
  single_list_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdy_ctrl_o & (rdy_mem_o | rdy_int_o | rdy_fp_o | rdy_misc_o)) |
     (rdy_mem_o & (rdy_int_o | rdy_fp_o | rdy_misc_o)) |
     (rdy_int_o & (rdy_fp_o | rdy_misc_o)) | (rdy_fp_o & rdy_misc_o)) == '0);

  // R12
  grant_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_i && valid_q[grant_idx_i] && !disp_valid_i && !squash_valid_i
    |=> free_cnt_o == $past(free_cnt_o) + 1'b1);

  // R9
  squash_no_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i && !disp_valid_i |=> free_cnt_o >= $past(free_cnt_o));

  // R6
  result_sets_sb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && ({1'b0, cmpl_tag_i} < PREG_LIM) &&
    !(disp_valid_i && disp_dst_valid_i && disp_dst_tag_i == cmpl_tag_i)
    |=> sb_ext[$past(cmpl_tag_i)]);

  // R3
  producer_clears_sb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && disp_dst_valid_i && ({1'b0, disp_dst_tag_i} < PREG_LIM)
    |=> !sb_ext[$past(disp_dst_tag_i)]);
endmodule

bind iq_wakeup_array iq_wakeup_chk #(
  .N_ENTRIES(N_ENTRIES), .N_PREGS(N_PREGS), .TAG_W(TAG_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .disp_valid_i     (disp_valid_i),
  .disp_dst_valid_i (disp_dst_valid_i),
  .disp_dst_tag_i   (disp_dst_tag_i),
  .cmpl_valid_i     (cmpl_valid_i),
  .cmpl_tag_i       (cmpl_tag_i),
  .squash_valid_i   (squash_valid_i),
  .grant_valid_i    (grant_valid_i),
  .grant_idx_i      (grant_idx_i),
  .rdy_ctrl_o       (rdy_ctrl_o),
  .rdy_mem_o        (rdy_mem_o),
  .rdy_int_o        (rdy_int_o),
  .rdy_fp_o         (rdy_fp_o),
  .rdy_misc_o       (rdy_misc_o),
  .free_cnt_o       (free_cnt_o),
  .full_o           (full_o),
  .valid_q          (entry_valid),
  .sb_q             (sb_vec)
);

// File: tb/tb_iq_wakeup_array.sv
`timescale 1ns/1ps
module tb_iq_wakeup_array;
  localparam int N  = 8;
  localparam int NP = 32;
  localparam int TW = 6;
  localparam int SW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_valid, disp_nonspec, s0_rdy, s1_rdy, dst_valid;
  logic [SW-1:0] disp_seq, sched_seq, squash_seq;
  logic [3:0] disp_flags;
  logic [TW-1:0] s0_tag, s1_tag, dst_tag, cmpl_tag;
  logic cmpl_valid, sched_valid, squash_valid, grant_valid;
  logic [2:0] grant_idx;
  logic [N-1:0] rdy_ctrl, rdy_mem, rdy_int, rdy_fp, rdy_misc;
  logic [3:0] free_cnt;
  logic full;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_v[N], m_w[N], m_r0[N], m_r1[N];
  int m_seq[N], m_cls[N], m_t0[N], m_t1[N];
  bit m_sb[NP];
  int seq_ctr;

  always #4 clk = ~clk;

  iq_wakeup_array dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_seq_i(disp_seq), .disp_flags_i(disp_flags),
    .disp_nonspec_i(disp_nonspec),
    .disp_src0_tag_i(s0_tag), .disp_src0_rdy_i(s0_rdy),
    .disp_src1_tag_i(s1_tag), .disp_src1_rdy_i(s1_rdy),
    .disp_dst_valid_i(dst_valid), .disp_dst_tag_i(dst_tag),
    .cmpl_valid_i(cmpl_valid), .cmpl_tag_i(cmpl_tag),
    .sched_valid_i(sched_valid), .sched_seq_i(sched_seq),
    .squash_valid_i(squash_valid), .squash_seq_i(squash_seq),
    .grant_valid_i(grant_valid), .grant_idx_i(grant_idx),
    .rdy_ctrl_o(rdy_ctrl), .rdy_mem_o(rdy_mem), .rdy_int_o(rdy_int),
    .rdy_fp_o(rdy_fp), .rdy_misc_o(rdy_misc),
    .free_cnt_o(free_cnt), .full_o(full)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int flag_cls(logic [3:0] f);
    if (f[0]) return 0;
    if (f[1]) return 1;
    if (f[2]) return 2;
    if (f[3]) return 3;
    return 4;
  endfunction

  function automatic int m_free();
    int c = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) c++;
    return c;
  endfunction

  // R6 R8: expected ready vector of one class, broadcast bypass included
  function automatic logic [N-1:0] exp_vec(int cls);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      bit h0 = cmpl_valid && (int'(cmpl_tag) == m_t0[i]);
      bit h1 = cmpl_valid && (int'(cmpl_tag) == m_t1[i]);
      v[i] = m_v[i] && !m_w[i] && (m_r0[i] || h0) && (m_r1[i] || h1) && (m_cls[i] == cls);
    end
    return v;
  endfunction

  task automatic compare_all();
    chk("R8", rdy_ctrl, exp_vec(0));
    chk("R8", rdy_mem,  exp_vec(1));
    chk("R8", rdy_int,  exp_vec(2));
    chk("R8", rdy_fp,   exp_vec(3));
    chk("R8", rdy_misc, exp_vec(4));
    chk("R2", free_cnt, m_free());
    chk("R10", full, m_free() == 0);
  endtask

  function automatic bit src_in(int tag, bit rdy);
    return disp_nonspec || rdy || tag >= NP || m_sb[tag] ||
           (cmpl_valid && int'(cmpl_tag) == tag);
  endfunction

  task automatic model_update();
    int idx = -1;
    bit acc;
    bit a0, a1;
    acc = disp_valid && (m_free() > 0);
    for (int i = 0; i < N; i++) if (!m_v[i] && idx < 0) idx = i;
    a0 = src_in(int'(s0_tag), s0_rdy);
    a1 = src_in(int'(s1_tag), s1_rdy);
    for (int i = 0; i < N; i++) begin
      if (m_v[i]) begin
        if ((grant_valid && int'(grant_idx) == i) ||
            (squash_valid && m_seq[i] > int'(squash_seq))) m_v[i] = 0;
        if (cmpl_valid && int'(cmpl_tag) == m_t0[i]) m_r0[i] = 1;
        if (cmpl_valid && int'(cmpl_tag) == m_t1[i]) m_r1[i] = 1;
        if (sched_valid && int'(sched_seq) == m_seq[i]) m_w[i] = 0;
      end
    end
    if (acc) begin
      m_v[idx] = 1; m_seq[idx] = int'(disp_seq); m_cls[idx] = flag_cls(disp_flags);
      m_w[idx] = disp_nonspec; m_t0[idx] = int'(s0_tag); m_t1[idx] = int'(s1_tag);
      m_r0[idx] = a0; m_r1[idx] = a1;
    end
    if (cmpl_valid && int'(cmpl_tag) < NP) m_sb[cmpl_tag] = 1;
    if (acc && dst_valid && int'(dst_tag) < NP) m_sb[dst_tag] = 0;
  endtask

  task automatic idle();
    disp_valid = 0; disp_nonspec = 0; disp_seq = '0; disp_flags = '0;
    s0_tag = '0; s0_rdy = 0; s1_tag = '0; s1_rdy = 0; dst_valid = 0; dst_tag = '0;
    cmpl_valid = 0; cmpl_tag = '0; sched_valid = 0; sched_seq = '0;
    squash_valid = 0; squash_seq = '0; grant_valid = 0; grant_idx = '0;
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_ni = 0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_r0[i] = 0; m_r1[i] = 0;
      m_seq[i] = 0; m_cls[i] = 4; m_t0[i] = 0; m_t1[i] = 0;
    end
    for (int i = 0; i < NP; i++) m_sb[i] = 0;
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic set_disp(int seq, logic [3:0] fl, bit ns, int t0, bit r0,
                          int t1, bit r1, bit dv, int dt);
    disp_valid = 1; disp_seq = SW'(seq); disp_flags = fl; disp_nonspec = ns;
    s0_tag = TW'(t0); s0_rdy = r0; s1_tag = TW'(t1); s1_rdy = r1;
    dst_valid = dv; dst_tag = TW'(dt);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    do_reset();

    #1;
    chk("R1", free_cnt, 8); chk("R1", full, 0);
    chk("R1", rdy_ctrl | rdy_mem | rdy_int | rdy_fp | rdy_misc, 0);

    set_disp(10, 4'b0100, 0, 5, 0, 40, 0, 1, 6); step();     // entry 0
    #1 chk("R2", free_cnt, 7); chk("R1", rdy_int, 8'h00);    // tag 5 not ready after reset
    cmpl_valid = 1; cmpl_tag = 5;
    #1 chk("R6", rdy_int, 8'h01);                            // same-cycle wakeup
    step();
    #1 chk("R6", rdy_int, 8'h01);

    set_disp(11, 4'b0011, 0, 5, 0, 44, 0, 1, 50); step();    // entry 1
    #1 chk("R4", rdy_ctrl, 8'h02); chk("R5", rdy_mem, 8'h00);

    cmpl_valid = 1; cmpl_tag = 6; step();
    set_disp(12, 4'b0100, 0, 40, 0, 41, 0, 1, 6); step();    // entry 2 produces tag 6
    set_disp(13, 4'b1000, 0, 6, 0, 6, 0, 0, 0); step();      // entry 3 waits on 6
    #1 chk("R3", rdy_fp, 8'h00); chk("R2", rdy_int, 8'h05);

    set_disp(14, 4'b0110, 0, 9, 0, 3, 1, 0, 0);
    cmpl_valid = 1; cmpl_tag = 9; step();                    // entry 4
    #1 chk("R7", rdy_mem, 8'h10);

    set_disp(15, 4'b0000, 1, 20, 0, 21, 0, 0, 0); step();    // entry 5 non-spec
    #1 chk("R11", rdy_misc, 8'h00);
    sched_valid = 1; sched_seq = 99; step();
    #1 chk("R11", rdy_misc, 8'h00);
    sched_valid = 1; sched_seq = 15; step();
    #1 chk("R11", rdy_misc, 8'h20); chk("R10", full, 0);

    grant_valid = 1; grant_idx = 1; step();
    #1 chk("R12", free_cnt, 3); chk("R12", rdy_ctrl, 8'h00);

    squash_valid = 1; squash_seq = 12; step();
    #1 chk("R9", free_cnt, 6); chk("R9", rdy_int, 8'h05);
    chk("R9", rdy_mem, 8'h00); chk("R9", rdy_misc, 8'h00);

    set_disp(20, 4'b0100, 0, 60, 0, 61, 0, 0, 0); step();
    #1 chk("R2", rdy_int, 8'h07);
    for (int k = 21; k < 26; k++) begin
      set_disp(k, 4'b0100, 0, 60, 0, 61, 0, 0, 0); step();
    end
    #1 chk("R10", full, 1); chk("R10", free_cnt, 0);

    // constrained random phase
    do_reset();
    seq_ctr = 10;
    for (int c = 0; c < 600; c++) begin
      if (m_free() > 0 && seq_ctr < 250 && ($urandom % 100) < 55) begin
        set_disp(seq_ctr, 4'($urandom % 16), ($urandom % 10) == 0,
                 int'($urandom % 40), ($urandom % 4) == 0,
                 int'($urandom % 40), ($urandom % 4) == 0,
                 ($urandom % 4) != 0, int'($urandom % 40));
        seq_ctr++;
      end
      if (($urandom % 100) < 40) begin cmpl_valid = 1; cmpl_tag = TW'($urandom % 40); end
      if (($urandom % 100) < 30) begin grant_valid = 1; grant_idx = 3'($urandom % 8); end
      if (($urandom % 100) < 15) begin
        sched_valid = 1; sched_seq = SW'(seq_ctr - 1 - int'($urandom % 8));
      end
      if (($urandom % 100) < 4) begin
        squash_valid = 1; squash_seq = SW'(seq_ctr - 1 - int'($urandom % 6));
      end
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule